// File: doc/BRIEF.md
# Shared Message-Buffer RAM Arbiter

This block is the front end of a 16-bit-wide RAM that stores message buffers and is shared by a CPU port and a protocol-engine port. The storage holds 15 buffers at fixed places. Each buffer is 8 words long. Words 0 and 1 hold the identifiers. Words 2 to 5 hold up to eight data bytes. Word 6 holds the timestamp and word 7 holds length, transmit priority and status. A reserved area of 8 words follows the last buffer.

The RAM serves one access per clock. A port that requests alone is granted in the same cycle. When both ports request in the same cycle, the engine wins the first such cycle. After that the grant alternates every cycle until one side stops requesting. A stalled port sees its ready signal low and holds its request until it is granted. The CPU port has byte lanes. A per-buffer busy input marks buffers that are being filled or are queued for transmission. The CPU cannot modify the contents of such a buffer, but it can still write the status word and read every word.

Top module: `msgbuf_arbiter`

## Requirements
- R1: After reset both ready outputs are low while no request is made, and both read-data outputs are zero.
- R2: A port that requests while the other port does not is ready in that same cycle. A granted write takes effect at that clock edge. A granted read's data appears on that port's read-data output from the next cycle.
- R3: The two ready outputs are never high in the same cycle. A port whose ready is low has no effect on memory or on its read data.
- R4: In a cycle where both ports request and the previous cycle did not have both requesting, the engine is granted.
- R5: In each further cycle of continued contention, the grant goes to the port that was not granted in the previous cycle.
- R6: CPU byte enable bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. Lanes whose enable is low keep their stored value. Reads always return the full word.
- R7: While busy bit b is high, a CPU write to address b*8+k with k from 0 to 6 is ready but leaves memory unchanged. A write to word k=7 of that buffer goes through. Reads of that buffer are unaffected.
- R8: Engine writes are always full-word writes and are never blocked by the busy bits.
- R9: Addresses 120 to 127 (the reserved words) read as zero from either port and ignore writes.
- R10: A port's read data holds its value until that port's next granted read. Granted writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_be | input | 2 | CPU byte enables for writes |
| cpu_addr | input | 7 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ready | output | 1 | CPU access granted this cycle |
| cpu_rdata | output | 16 | CPU read data, registered |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | 7 | Engine word address |
| eng_wdata | input | 16 | Engine write data |
| eng_ready | output | 1 | Engine access granted this cycle |
| eng_rdata | output | 16 | Engine read data, registered |
| buf_busy | input | 15 | Per-buffer busy flags that gate CPU writes |

## Verification
The assertions assume that a port whose ready is low keeps its request, direction and address unchanged into the next cycle. Without that, the alternation checks of R5 would compare unrelated accesses. The bench drives every port from tasks that change the request, direction and address only at the falling edge that follows a grant. Between accesses the bench drops the request, so each access is either uncontended or part of a contention run that the bench starts on purpose. The busy flags change only while the CPU is idle.

// File: rtl/msgbuf_arb_pkg.sv
package msgbuf_arb_pkg;
    localparam int WORD_W    = 16;
    localparam int NUM_BUFS  = 15;
    localparam int BUF_WORDS = 8;
    localparam int RSVD_W    = 8;

    typedef struct packed {
        logic cont;      // previous cycle had both ports requesting
        logic eng_last;  // engine won the previous contended cycle
    } arb_state_t;
endpackage

// File: rtl/msgbuf_grant.sv
module msgbuf_grant
    import msgbuf_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic eng_req,
    output logic cpu_gnt,
    output logic eng_gnt
);
    arb_state_t st_d, st_q;
    logic both;
    logic eng_first;

    always_comb begin
        both      = cpu_req && eng_req;
        // engine leads a fresh contention run, then the turn toggles
        eng_first = !st_q.cont || !st_q.eng_last;
        eng_gnt   = eng_req && (!cpu_req || eng_first);
        cpu_gnt   = cpu_req && !eng_gnt;
        st_d      = st_q;
        st_d.cont = both;
        st_d.eng_last = both && eng_gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/msgbuf_wgate.sv
module msgbuf_wgate #(
    parameter int NUM_BUFS  = 15,
    parameter int BUF_WORDS = 8,
    parameter int ADDR_W    = 7,
    parameter int BE_W      = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BE_W-1:0]     be,
    input  logic [NUM_BUFS-1:0] busy,
    output logic [BE_W-1:0]     be_eff
);
    localparam int OFF_W = $clog2(BUF_WORDS);
    localparam int IDX_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] off;
    logic             hit_busy;
    logic             locked;

    always_comb begin
        idx      = addr[ADDR_W-1:OFF_W];
        off      = addr[OFF_W-1:0];
        hit_busy = 1'b0;
        for (int i = 0; i < NUM_BUFS; i++) begin
            if (idx == IDX_W'(i) && busy[i]) hit_busy = 1'b1;
        end
        // last word of a buffer is status/control and stays writable
        locked = hit_busy && (off != OFF_W'(BUF_WORDS - 1));
        be_eff = locked ? '0 : be;
    end
endmodule

// File: rtl/msgbuf_store.sv
module msgbuf_store #(
    parameter int DATA_W    = 16,
    parameter int NUM_WORDS = 120,
    parameter int ADDR_W    = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] mem [NUM_WORDS];
    logic in_range;

    always_comb begin
        in_range = 32'(addr) < NUM_WORDS;
        rdata    = in_range ? mem[addr] : '0;
    end

    for (genvar l = 0; l < BE_W; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && in_range && wr_be[l])
                mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
        end
    end
endmodule

// File: rtl/msgbuf_arbiter.sv
module msgbuf_arbiter
    import msgbuf_arb_pkg::*;
#(
    parameter int DATA_W    = WORD_W,
    parameter int NBUF      = NUM_BUFS,
    parameter int BWORDS    = BUF_WORDS,
    parameter int RSVD      = RSVD_W,
    parameter int ADDR_W    = $clog2(NBUF * BWORDS + RSVD),
    parameter int BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic              eng_ready,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic [NBUF-1:0]   buf_busy
);
    localparam int NUM_WORDS = NBUF * BWORDS;

    typedef struct packed {
        logic [DATA_W-1:0] cpu_rd;
        logic [DATA_W-1:0] eng_rd;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic cpu_gnt, eng_gnt;
    logic [BE_W-1:0]   cpu_be_eff;
    logic              m_we;
    logic [BE_W-1:0]   m_be;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W-1:0] m_rdata;

    msgbuf_grant u_grant (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_req (cpu_req),
        .eng_req (eng_req),
        .cpu_gnt (cpu_gnt),
        .eng_gnt (eng_gnt)
    );

    msgbuf_wgate #(
        .NUM_BUFS  (NBUF),
        .BUF_WORDS (BWORDS),
        .ADDR_W    (ADDR_W),
        .BE_W      (BE_W)
    ) u_wgate (
        .addr   (cpu_addr),
        .be     (cpu_be),
        .busy   (buf_busy),
        .be_eff (cpu_be_eff)
    );

    msgbuf_store #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_store (
        .clk   (clk),
        .wr_en (m_we),
        .wr_be (m_be),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (m_rdata)
    );

    always_comb begin
        m_addr  = eng_gnt ? eng_addr  : cpu_addr;
        m_wdata = eng_gnt ? eng_wdata : cpu_wdata;
        m_be    = eng_gnt ? '1        : cpu_be_eff;
        m_we    = (eng_gnt && eng_we) || (cpu_gnt && cpu_we);
        rd_d    = rd_q;
        if (cpu_gnt && !cpu_we) rd_d.cpu_rd = m_rdata;
        if (eng_gnt && !eng_we) rd_d.eng_rd = m_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign cpu_ready = cpu_gnt;
    assign eng_ready = eng_gnt;
    assign cpu_rdata = rd_q.cpu_rd;
    assign eng_rdata = rd_q.eng_rd;
endmodule

// File: rtl/msgbuf_arbiter_chk.sv
module msgbuf_arbiter_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              eng_req,
    input logic              cpu_ready,
    input logic              eng_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [DATA_W-1:0] eng_rdata
);
    logic prev_cont_q, prev_eng_q, cpu_rd_q, eng_rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_cont_q <= 1'b0;
            prev_eng_q  <= 1'b0;
            cpu_rd_q    <= 1'b0;
            eng_rd_q    <= 1'b0;
        end else begin
            prev_cont_q <= cpu_req && eng_req;
            prev_eng_q  <= eng_ready;
            cpu_rd_q    <= 1'b1;
            eng_rd_q    <= 1'b1;
        end
    end

    // R3: one grant per cycle
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && eng_ready));

    // R2: a lone requester is granted at once
    a_r2_cpu_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !eng_req) |-> cpu_ready);
    a_r2_eng_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !cpu_req) |-> eng_ready);

    // R4: engine leads a fresh contention run
    a_r4_eng_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && eng_req && !prev_cont_q) |-> eng_ready);

    // R5: grants alternate while contention lasts
    a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && eng_req && prev_cont_q) |-> (eng_ready != prev_eng_q));

    // R3: a stalled CPU keeps its access pending
    a_r3_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |=> (cpu_req && $stable(cpu_addr) && $stable(cpu_we)));

    // R10: read data moves only after a granted access
    a_r10_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_q && !$past(cpu_ready)) |-> $stable(cpu_rdata));
    a_r10_eng_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rd_q && !$past(eng_ready)) |-> $stable(eng_rdata));
endmodule

bind msgbuf_arbiter msgbuf_arbiter_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .eng_req   (eng_req),
    .cpu_ready (cpu_ready),
    .eng_ready (eng_ready),
    .cpu_rdata (cpu_rdata),
    .eng_rdata (eng_rdata)
);

// File: tb/tb_msgbuf_arbiter.sv
module tb_msgbuf_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req = 0, cpu_we = 0;
    logic [1:0]  cpu_be = 0;
    logic [6:0]  cpu_addr = 0;
    logic [15:0] cpu_wdata = 0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        eng_req = 0, eng_we = 0;
    logic [6:0]  eng_addr = 0;
    logic [15:0] eng_wdata = 0;
    logic        eng_ready;
    logic [15:0] eng_rdata;
    logic [14:0] buf_busy = 0;

    int checks = 0, fails = 0;
    bit done = 0;

    msgbuf_arbiter dut (.*);

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(logic [6:0] a, logic [1:0] be, logic [15:0] d, string tag);
        logic [15:0] hold;
        @(negedge clk);
        hold = cpu_rdata;
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_be = be; cpu_wdata = d;
        #5 chk({tag, " ready"}, cpu_ready, 1);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        chk("R10 write keeps rdata", cpu_rdata, hold);
    endtask

    task automatic cpu_rd(logic [6:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        #5 chk("R2 cpu ready", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 0;
        chk(tag, cpu_rdata, exp);
    endtask

    task automatic eng_wr(logic [6:0] a, logic [15:0] d);
        @(negedge clk);
        eng_req = 1; eng_we = 1; eng_addr = a; eng_wdata = d;
        #5 chk("R2 eng ready", eng_ready, 1);
        @(negedge clk);
        eng_req = 0; eng_we = 0;
    endtask

    task automatic eng_rd(logic [6:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        eng_req = 1; eng_we = 0; eng_addr = a;
        #5 chk("R2 eng ready", eng_ready, 1);
        @(negedge clk);
        eng_req = 0;
        chk(tag, eng_rdata, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cpu_ready", cpu_ready, 0);
        chk("R1 eng_ready", eng_ready, 0);
        chk("R1 cpu_rdata", cpu_rdata, 0);
        chk("R1 eng_rdata", eng_rdata, 0);
    endtask

    task automatic t_single();
        cpu_wr(7'd10, 2'b11, 16'hA55A, "R2 cpu");
        cpu_rd(7'd10, 16'hA55A, "R2 cpu readback");
        eng_wr(7'd11, 16'h1234);
        eng_rd(7'd11, 16'h1234, "R2 eng readback");
        cpu_rd(7'd11, 16'h1234, "R2 cross read");
        // R10: idle cycles keep read data
        repeat (3) @(negedge clk);
        chk("R10 cpu hold", cpu_rdata, 16'h1234);
        chk("R10 eng hold", eng_rdata, 16'h1234);
    endtask

    task automatic t_bytes();
        cpu_wr(7'd20, 2'b11, 16'h0000, "R6");
        cpu_wr(7'd20, 2'b01, 16'hFFC3, "R6 low lane");
        cpu_rd(7'd20, 16'h00C3, "R6 low lane only");
        cpu_wr(7'd20, 2'b10, 16'h7E11, "R6 high lane");
        cpu_rd(7'd20, 16'h7EC3, "R6 high lane only");
        cpu_wr(7'd20, 2'b00, 16'h9999, "R6 no lane");
        cpu_rd(7'd20, 16'h7EC3, "R6 no lane keeps");
    endtask

    task automatic t_busy();
        cpu_wr(7'd26, 2'b11, 16'h0D0D, "R7 prep");
        cpu_wr(7'd24, 2'b11, 16'h0101, "R7 prep");
        cpu_wr(7'd31, 2'b11, 16'h0F0F, "R7 prep");
        buf_busy = 15'b1 << 3;
        cpu_wr(7'd26, 2'b11, 16'hBEEF, "R7 blocked");
        cpu_wr(7'd24, 2'b01, 16'hBEEF, "R7 blocked");
        cpu_wr(7'd31, 2'b11, 16'h5A5A, "R7 status");
        cpu_wr(7'd34, 2'b11, 16'h4242, "R7 other buffer");
        cpu_rd(7'd26, 16'h0D0D, "R7 data unchanged");
        cpu_rd(7'd24, 16'h0101, "R7 id unchanged");
        cpu_rd(7'd31, 16'h5A5A, "R7 status written");
        cpu_rd(7'd34, 16'h4242, "R7 other buffer written");
        eng_wr(7'd27, 16'hC0DE);
        eng_rd(7'd27, 16'hC0DE, "R8 engine writes busy buffer");
        buf_busy = 0;
        cpu_wr(7'd26, 2'b11, 16'hBEEF, "R7 released");
        cpu_rd(7'd26, 16'hBEEF, "R7 write after release");
    endtask

    task automatic t_reserved();
        cpu_wr(7'd120, 2'b11, 16'hFFFF, "R9");
        eng_wr(7'd127, 16'hFFFF);
        cpu_rd(7'd120, 16'h0000, "R9 cpu reserved");
        eng_rd(7'd127, 16'h0000, "R9 eng reserved");
        cpu_wr(7'd119, 2'b11, 16'h7777, "R9 last word");
        eng_rd(7'd119, 16'h7777, "R9 last real word");
    endtask

    task automatic t_contend();
        for (int i = 0; i < 8; i++) begin
            eng_wr(7'(40 + i), 16'hE000 + 16'(i));
            eng_wr(7'(60 + i), 16'hC000 + 16'(i));
        end
        for (int round = 0; round < 2; round++) begin
            int ei = 0, ci = 0;
            @(negedge clk);
            eng_req = 1; eng_we = 0; eng_addr = 7'd40;
            cpu_req = 1; cpu_we = 0; cpu_addr = 7'd60;
            for (int k = 0; k < 6; k++) begin
                logic eg;
                #5;
                eg = eng_ready;
                chk((k == 0) ? "R4 engine first" : "R5 alternate", eg, (k % 2 == 0));
                chk("R3 one ready", eng_ready & cpu_ready, 0);
                @(negedge clk);
                if (eg) begin
                    chk("R5 eng data", eng_rdata, 16'hE000 + 16'(ei));
                    ei++; eng_addr = 7'(40 + ei);
                end else begin
                    chk("R5 cpu data", cpu_rdata, 16'hC000 + 16'(ci));
                    ci++; cpu_addr = 7'(60 + ci);
                end
            end
            eng_req = 0;
            #5 chk("R2 cpu alone after contention", cpu_ready, 1);
            @(negedge clk);
            cpu_req = 0;
            chk("R3 stalled cpu read then served", cpu_rdata, 16'hC000 + 16'(ci));
        end
        // stalled CPU write takes effect only when granted
        @(negedge clk);
        eng_req = 1; eng_we = 0; eng_addr = 7'd40;
        cpu_req = 1; cpu_we = 1; cpu_be = 2'b11; cpu_addr = 7'd41; cpu_wdata = 16'h3333;
        #5 chk("R3 cpu stalled", cpu_ready, 0);
        @(negedge clk);
        eng_addr = 7'd41;
        #5 chk("R5 cpu turn", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        chk("R3 stalled write not applied early", eng_rdata, 16'hE000);
        #5 chk("R2 eng alone", eng_ready, 1);
        @(negedge clk);
        eng_req = 0;
        chk("R3 write applied on grant", eng_rdata, 16'h3333);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_bytes();
        t_busy();
        t_reserved();
        t_contend();
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule